// File: doc/BRIEF.md
# GPIO Port with Timer Override

This block is a seven-pin general-purpose I/O port behind a small register interface. Two registers are mapped on the bus: a data latch at address 0x09 and a direction register at address 0x0D. A pin whose direction bit is 1 drives its latch bit out. A pin whose direction bit is 0 is an input, and its level can be read back through a two-flop synchronizer.

Six of the seven pins can be claimed by timer channels. Pins 0 to 3 belong to the channels of timer A, and pins 4 and 5 belong to the channels of timer B. While a channel claims its pin, the timer alone sets the pin's drive value and output enable. A read of the data address still picks its source from the direction register: the latch where the bit is 1, and the synchronized pin where it is 0. Pin 6 has no timer function. The data latch has no reset. The direction register clears on reset, so every pin starts as an input.

Top module: `gpio_tmr_port`

## Requirements
- R1: While reset is asserted and after it is released, every direction bit is 0, a read of address 0x0D returns 0x00, and pins that no timer claims have output enable 0.
- R2: A write strobe to address 0x0D loads data bits 6..0 into the direction register on the next rising clock edge. Until that edge the old value reads back. Bit 7 of the read value is always 0.
- R3: A write strobe to address 0x09 loads data bits 6..0 into the data latch on the next rising clock edge. Bit 7 of a data read is always 0.
- R4: Reset does not change the data latch. A value written before reset is driven and read back unchanged after reset.
- R5: For a pin that no timer claims, the output enable equals its direction bit and the drive value equals its latch bit.
- R6: For pin i in 0..3, while timer A claim bit i is 1, the pin's drive value and output enable equal timer A drive bit i and enable bit i, whatever the direction bit is.
- R7: For pin 4+j with j in 0..1, while timer B claim bit j is 1, the pin's drive value and output enable equal timer B drive bit j and enable bit j, whatever the direction bit is.
- R8: Pin 6 ignores every timer input and always follows its own direction and latch bits.
- R9: Reading address 0x09 returns, for each bit, the latch bit where the direction bit is 1 and the synchronized pin level where it is 0. This holds whether or not a timer claims the pin. Any other address reads 0x00.
- R10: A change on a pin input shows in a data read after the second rising clock edge that follows it, and not after the first.
- R11: A write to an address other than 0x09 or 0x0D changes neither register. Neither register changes while the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 7 | Write data for the implemented bits 6..0 |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 7 | Pin levels from the pads |
| pin_out | output | 7 | Pin drive values |
| pin_oe | output | 7 | Pin output enables |
| ta_own | input | 4 | Timer A channel claims pins 0..3 |
| ta_drv | input | 4 | Timer A channel drive values |
| ta_oe | input | 4 | Timer A channel output enables |
| tb_own | input | 2 | Timer B channel claims pins 4..5 |
| tb_drv | input | 2 | Timer B channel drive values |
| tb_oe | input | 2 | Timer B channel output enables |

## Verification
The pin drive and output enable follow the timer inputs with no delay, and they follow register contents one edge after the write strobe. Both are sampled one time unit after a rising edge. A register write shows in reads after one edge, and the bench also samples before that edge to confirm the old value. A pin-input change needs two edges to reach a data read. The bench changes the pin at a falling edge and checks after the first rising edge, where the old value is expected, and again after the second, where the new value is expected. Table vectors wait three edges after their last change, so every path has settled before sampling.

// File: rtl/gpio_tmr_port.sv
module gpio_tmr_port #(
  parameter int NPIN = 7,
  parameter int NTA = 4,
  parameter int NTB = 2,
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] DATA_ADDR = 8'h09,
  parameter logic [AW-1:0] DIR_ADDR = 8'h0D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  input  logic [NTA-1:0]  ta_own,
  input  logic [NTA-1:0]  ta_drv,
  input  logic [NTA-1:0]  ta_oe,
  input  logic [NTB-1:0]  tb_own,
  input  logic [NTB-1:0]  tb_drv,
  input  logic [NTB-1:0]  tb_oe
);
  localparam int TB_END = NTA + NTB;
  localparam int PAD = DW - NPIN;

  logic [NPIN-1:0] dir_q, lat_q, sync1_q, sync2_q;
  logic [NPIN-1:0] own, t_drv, t_oe, rd_port;

  wire wr_dir = bus_wr && (bus_addr == DIR_ADDR);
  wire wr_dat = bus_wr && (bus_addr == DATA_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dir_q <= '0;
    else if (wr_dir) dir_q <= bus_wdata;

  always_ff @(posedge clk)
    if (wr_dat) lat_q <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    if (g < NTA) begin : g_ta
      assign own[g]   = ta_own[g];
      assign t_drv[g] = ta_drv[g];
      assign t_oe[g]  = ta_oe[g];
    end else if (g < TB_END) begin : g_tb
      assign own[g]   = tb_own[g-NTA];
      assign t_drv[g] = tb_drv[g-NTA];
      assign t_oe[g]  = tb_oe[g-NTA];
    end else begin : g_plain
      assign own[g]   = 1'b0;
      assign t_drv[g] = 1'b0;
      assign t_oe[g]  = 1'b0;
    end
    assign pin_out[g] = own[g] ? t_drv[g] : lat_q[g];
    assign pin_oe[g]  = own[g] ? t_oe[g]  : dir_q[g];
  end

  assign rd_port = (dir_q & lat_q) | (~dir_q & sync2_q);

  always_comb
    if (bus_addr == DATA_ADDR)     bus_rdata = {{PAD{1'b0}}, rd_port};
    else if (bus_addr == DIR_ADDR) bus_rdata = {{PAD{1'b0}}, dir_q};
    else                           bus_rdata = '0;
endmodule

module gpio_tmr_port_chk #(
  parameter int NPIN = 7,
  parameter int NTA = 4,
  parameter int NTB = 2,
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] DATA_ADDR = 8'h09,
  parameter logic [AW-1:0] DIR_ADDR = 8'h0D
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic [NPIN-1:0] bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic [NTA-1:0]  ta_own,
  input logic [NTA-1:0]  ta_drv,
  input logic [NTA-1:0]  ta_oe,
  input logic [NTB-1:0]  tb_own,
  input logic [NTB-1:0]  tb_drv,
  input logic [NTB-1:0]  tb_oe,
  input logic [NPIN-1:0] dir_q,
  input logic [NPIN-1:0] lat_q
);
  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DIR_ADDR) |=> dir_q == $past(bus_wdata));

  assert_lat_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DATA_ADDR) |=> lat_q == $past(bus_wdata));

  assert_dir_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == DIR_ADDR) |=> $stable(dir_q));

  assert_rd_msb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1] == 1'b0);

  assert_pin6_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[NPIN-1] == dir_q[NPIN-1]);

  for (genvar i = 0; i < NTA; i++) begin : g_a
    assert_ta_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ta_own[i] |-> (pin_out[i] == ta_drv[i] && pin_oe[i] == ta_oe[i]));
    assert_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ta_own[i] |-> (pin_oe[i] == dir_q[i]));
  end
  for (genvar j = 0; j < NTB; j++) begin : g_b
    assert_tb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tb_own[j] |-> (pin_out[NTA+j] == tb_drv[j] && pin_oe[NTA+j] == tb_oe[j]));
  end
endmodule

bind gpio_tmr_port gpio_tmr_port_chk #(
  .NPIN(NPIN), .NTA(NTA), .NTB(NTB), .AW(AW), .DW(DW),
  .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
  .pin_oe(pin_oe), .ta_own(ta_own), .ta_drv(ta_drv), .ta_oe(ta_oe),
  .tb_own(tb_own), .tb_drv(tb_drv), .tb_oe(tb_oe), .dir_q(dir_q),
  .lat_q(lat_q)
);

// File: tb/gpio_tmr_port_bench.sv
module gpio_tmr_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic bus_wr = 1'b0;
  logic [6:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] pin_in = '0, pin_out, pin_oe;
  logic [3:0] ta_own = '0, ta_drv = '0, ta_oe = '0;
  logic [1:0] tb_own = '0, tb_drv = '0, tb_oe = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_tmr_port u_gpio_tmr_port (.*);

  typedef struct packed {
    logic [6:0] dir, lat, pin;
    logic [3:0] aown, adrv, aoe;
    logic [1:0] bown, bdrv, boe;
    logic [6:0] eout, eoe;
    logic [7:0] erd;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{7'h7F, 7'h55, 7'h00, 4'h0, 4'h0, 4'h0, 2'h0, 2'h0, 2'h0, 7'h55, 7'h7F, 8'h55},
    '{7'h00, 7'h2A, 7'h5A, 4'h0, 4'h0, 4'h0, 2'h0, 2'h0, 2'h0, 7'h2A, 7'h00, 8'h5A},
    '{7'h0F, 7'h33, 7'h70, 4'hF, 4'hA, 4'h5, 2'h0, 2'h0, 2'h0, 7'h3A, 7'h05, 8'h73},
    '{7'h30, 7'h4C, 7'h0F, 4'h0, 4'h0, 4'h0, 2'h3, 2'h1, 2'h2, 7'h5C, 7'h20, 8'h0F},
    '{7'h7F, 7'h00, 7'h00, 4'h5, 4'hF, 4'hF, 2'h2, 2'h2, 2'h2, 7'h25, 7'h7F, 8'h00},
    '{7'h40, 7'h40, 7'h3F, 4'hF, 4'h0, 4'h0, 2'h3, 2'h0, 2'h0, 7'h40, 7'h40, 8'h7F}
  };

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [6:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    bus_addr = a;
    #1;
    check(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rd_chk(8'h0D, 8'h00, "R1 dir in reset");
    check(pin_oe === 7'h00, "R1 oe in reset", {1'b0, pin_oe}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    rd_chk(8'h0D, 8'h00, "R1 dir after reset");

    foreach (VEC[k]) begin
      wr(8'h0D, VEC[k].dir);
      wr(8'h09, VEC[k].lat);
      pin_in = VEC[k].pin;
      ta_own = VEC[k].aown; ta_drv = VEC[k].adrv; ta_oe = VEC[k].aoe;
      tb_own = VEC[k].bown; tb_drv = VEC[k].bdrv; tb_oe = VEC[k].boe;
      repeat (3) @(posedge clk);
      #1;
      check(pin_out === VEC[k].eout, "R5 R6 R7 R8 pin_out", {1'b0, pin_out}, {1'b0, VEC[k].eout});
      check(pin_oe === VEC[k].eoe, "R5 R6 R7 R8 pin_oe", {1'b0, pin_oe}, {1'b0, VEC[k].eoe});
      rd_chk(8'h09, VEC[k].erd, "R9 data read");
    end
    ta_own = '0; tb_own = '0;

    // R2: old value before the edge, new value after
    @(negedge clk);
    bus_addr = 8'h0D; bus_wr = 1'b1; bus_wdata = 7'h7F;
    #1;
    check(bus_rdata === 8'h40, "R2 before edge", bus_rdata, 8'h40);
    @(posedge clk); #1;
    rd_chk(8'h0D, 8'h7F, "R2 after edge");
    @(negedge clk); bus_wr = 1'b0;

    // R3: latch write and bit 7 read as 0
    wr(8'h09, 7'h7E);
    #1; rd_chk(8'h09, 8'h7E, "R3 latch read");

    // R11: other address and idle strobe
    wr(8'h0A, 7'h00);
    #1; rd_chk(8'h0D, 8'h7F, "R11 other address dir");
    rd_chk(8'h09, 8'h7E, "R11 other address latch");
    rd_chk(8'h0A, 8'h00, "R9 unmapped read");
    @(negedge clk); bus_addr = 8'h0D; bus_wdata = 7'h00;
    @(posedge clk); #1;
    rd_chk(8'h0D, 8'h7F, "R11 strobe low");

    // R4: latch survives reset
    wr(8'h09, 7'h2D);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(pin_out === 7'h2D, "R4 drive after reset", {1'b0, pin_out}, 8'h2D);
    rd_chk(8'h0D, 8'h00, "R1 dir after second reset");
    wr(8'h0D, 7'h7F);
    #1; rd_chk(8'h09, 8'h2D, "R4 latch after reset");

    // R10: two-stage input path
    wr(8'h0D, 7'h00);
    pin_in = 7'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); pin_in = 7'h7F;
    @(posedge clk); #1;
    rd_chk(8'h09, 8'h00, "R10 after one edge");
    @(posedge clk); #1;
    rd_chk(8'h09, 8'h7F, "R10 after two edges");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule